// File: doc/BRIEF.md
# Partial Array Self-Refresh Controller

This block drives the refresh side of a low-power DRAM while the device sleeps and keeps only part of its array alive. A configuration word, written through the extended-mode-register path, picks one of four retention geometries. The first keeps a prefix fraction of the array. The second keeps a fraction taken from the bottom or the top of an eight-bank array. The third keeps any set of banks. The fourth keeps any set of half-banks. Each write is decoded at once into a sixteen-entry half-bank retention mask. That mask is staged and only becomes active when the device enters self-refresh.

During self-refresh an internal timer fires once every `REF_DIV` cycles. Each firing advances a bank/row position counter. The block emits a refresh strobe with that bank and row only when the half-bank holding the row is retained; all other strobes are suppressed. At each sleep entry, every bank that is not fully retained is flagged invalid. The flag stays set through wake-up until the first ordinary write to that bank.

Top module: `psr_ctrl`

## Requirements
- R1: After reset `in_sr`, `ref_stb`, `cfg_err` and `bank_invalid` are all zero, `retain_mask` is 8'hFF, and the staged setting keeps the whole array.
- R2: `cfg_data[17:16]` selects the mode: 0 prefix, 1 end-anchored, 2 bank mask, 3 half-bank mask. In mode 0, `cfg_data[2:0]` code 0 keeps all 16 half-banks, code 1 keeps the lowest 8, code 2 the lowest 4, code 5 the lowest 2 and code 6 the lowest 1.
- R3: A mode-0 write with code 3, 4 or 7 leaves the staged setting unchanged and raises `cfg_err` for exactly the one cycle after the write; every accepted write leaves `cfg_err` low.
- R4: In mode 1, `cfg_data[1:0]` = 0, 1, 2 or 3 keeps 16, 8, 4 or 2 half-banks. They are taken from half-bank 0 upward when `cfg_data[2]`=0 and from half-bank 15 downward when it is 1.
- R5: In mode 2, `cfg_data[b]` retains both halves of bank b, for b from 0 to 7.
- R6: In mode 3, `cfg_data[2b]` retains the lower half of bank b (row MSB 0) and `cfg_data[2b+1]` retains its upper half (row MSB 1).
- R7: A configuration write has no effect on refresh or on `retain_mask` until the next sleep entry, including a write received during self-refresh. At entry, `retain_mask[b]` becomes 1 exactly when both halves of bank b are retained.
- R8: One cycle after an accepted `sleep_enter`, `in_sr` is 1 and the bank/row position restarts at bank 0, row 0. The position then advances every `REF_DIV` cycles, row first and then bank, and wraps. The first step lands `REF_DIV` cycles after entry. `ref_stb` pulses for one cycle at a step only when the stepped row's half-bank is retained, and never outside self-refresh.
- R9: At each sleep entry, `bank_invalid[b]` is set for every bank that is not fully retained, and set flags stay set. A `wr_stb` to bank `wr_bank` clears that flag only outside self-refresh; during self-refresh it is ignored.
- R10: `sleep_enter` while already in self-refresh and `sleep_exit` while awake have no effect; `sleep_exit` drops `in_sr` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 18 | Mode and retention parameter |
| sleep_enter | input | 1 | Request entry into self-refresh |
| sleep_exit | input | 1 | Request exit from self-refresh |
| wr_stb | input | 1 | Ordinary write to a bank (clears its invalid flag) |
| wr_bank | input | 3 | Bank of the ordinary write |
| in_sr | output | 1 | Device is in self-refresh |
| ref_stb | output | 1 | Refresh strobe to a retained row |
| ref_bank | output | 3 | Bank of the latest refresh step |
| ref_row | output | ROW_W | Row of the latest refresh step |
| retain_mask | output | 8 | Banks fully retained by the active setting |
| bank_invalid | output | 8 | Banks whose contents were lost |
| cfg_err | output | 1 | Rejected configuration write |

## Verification
The bench builds the block with `ROW_W`=2 and `REF_DIV`=3, so one full sweep of all 32 bank/row positions takes only 96 cycles. This lets every sleep period cover whole sweeps, wrap the position counter, and cross both halves of every bank. Holding a sleep for a chosen length brings several cases into reach: an exit that coincides with a refresh step, a write accepted during sleep and applied at the following entry, and the set/clear interplay of the invalid flags across several entries.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int NBANK  = 8;
  localparam int NHALF  = 2 * NBANK;
  localparam int BANK_W = $clog2(NBANK);
  localparam int HALF_W = $clog2(NHALF);
  localparam int CFG_W  = 18;

  typedef enum logic [1:0] {
    MODE_PREFIX = 2'd0,
    MODE_ENDS   = 2'd1,
    MODE_BANKS  = 2'd2,
    MODE_HALVES = 2'd3
  } psr_mode_e;

  // bank is fully kept only when both of its halves are kept
  function automatic logic [NBANK-1:0] whole_banks(input logic [NHALF-1:0] h);
    logic [NBANK-1:0] r;
    for (int b = 0; b < NBANK; b++) r[b] = h[2*b] & h[2*b+1];
    return r;
  endfunction
endpackage

// File: rtl/psr_cfg_decode.sv
module psr_cfg_decode
  import psr_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_data,
  output logic [NHALF-1:0] half_mask,
  output logic             bad
);
  psr_mode_e mode;
  int        keep;

  always_comb begin
    mode      = psr_mode_e'(cfg_data[17:16]);
    half_mask = '0;
    bad       = 1'b0;
    keep      = NHALF;
    case (mode)
      MODE_PREFIX: begin
        case (cfg_data[2:0])
          3'd0:    keep = NHALF;
          3'd1:    keep = NHALF / 2;
          3'd2:    keep = NHALF / 4;
          3'd5:    keep = NHALF / 8;
          3'd6:    keep = NHALF / 16;
          default: bad  = 1'b1;
        endcase
        for (int h = 0; h < NHALF; h++) half_mask[h] = (h < keep);
      end
      MODE_ENDS: begin
        keep = NHALF >> cfg_data[1:0];
        for (int h = 0; h < NHALF; h++)
          half_mask[h] = cfg_data[2] ? (h >= NHALF - keep) : (h < keep);
      end
      MODE_BANKS: begin
        for (int b = 0; b < NBANK; b++) begin
          half_mask[2*b]   = cfg_data[b];
          half_mask[2*b+1] = cfg_data[b];
        end
      end
      default: half_mask = cfg_data[NHALF-1:0];
    endcase
  end
endmodule

// File: rtl/psr_refresh_seq.sv
module psr_refresh_seq
  import psr_pkg::*;
#(
  parameter int ROW_W   = 6,
  parameter int REF_DIV = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             in_sr,
  input  logic [NHALF-1:0] act_half,
  output logic             ref_stb,
  output logic [BANK_W-1:0] ref_bank,
  output logic [ROW_W-1:0] ref_row
);
  localparam int TW    = (REF_DIV > 2) ? $clog2(REF_DIV) : 1;
  localparam int POS_W = BANK_W + ROW_W;

  logic [TW-1:0]    tmr;
  logic [POS_W-1:0] pos;
  logic             step;
  logic [HALF_W-1:0] hidx;

  assign step = in_sr && (tmr == TW'(REF_DIV - 1));
  assign hidx = {pos[POS_W-1:ROW_W], pos[ROW_W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr      <= '0;
      pos      <= '0;
      ref_stb  <= 1'b0;
      ref_bank <= '0;
      ref_row  <= '0;
    end else if (start) begin
      tmr     <= '0;
      pos     <= '0;
      ref_stb <= 1'b0;
    end else if (step) begin
      tmr      <= '0;
      pos      <= pos + 1'b1;
      ref_stb  <= act_half[hidx];
      ref_bank <= pos[POS_W-1:ROW_W];
      ref_row  <= pos[ROW_W-1:0];
    end else begin
      if (in_sr) tmr <= tmr + 1'b1;
      ref_stb <= 1'b0;
    end
  end

  // R8: strobes are single-cycle, REF_DIV >= 2 apart
  a_r8_stb_single: assert property (@(posedge clk) disable iff (rst)
    ref_stb |=> !ref_stb);
endmodule

// File: rtl/psr_bank_track.sv
module psr_bank_track
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              entry,
  input  logic [NBANK-1:0]  drop,
  input  logic              in_sr,
  input  logic              wr_stb,
  input  logic [BANK_W-1:0] wr_bank,
  output logic [NBANK-1:0]  bank_invalid
);
  always_ff @(posedge clk) begin
    if (rst)
      bank_invalid <= '0;
    else if (entry)
      bank_invalid <= bank_invalid | drop;
    else if (wr_stb && !in_sr)
      bank_invalid[wr_bank] <= 1'b0;
  end

  // R9: flags never change while the array sleeps past the entry cycle
  a_r9_hold_in_sleep: assert property (@(posedge clk) disable iff (rst)
    (in_sr && $past(in_sr)) |-> $stable(bank_invalid));
endmodule

// File: rtl/psr_ctrl.sv
module psr_ctrl
  import psr_pkg::*;
#(
  parameter int ROW_W   = 6,
  parameter int REF_DIV = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic              sleep_enter,
  input  logic              sleep_exit,
  input  logic              wr_stb,
  input  logic [BANK_W-1:0] wr_bank,
  output logic              in_sr,
  output logic              ref_stb,
  output logic [BANK_W-1:0] ref_bank,
  output logic [ROW_W-1:0]  ref_row,
  output logic [NBANK-1:0]  retain_mask,
  output logic [NBANK-1:0]  bank_invalid,
  output logic              cfg_err
);
  logic [NHALF-1:0] dec_mask, staged, active;
  logic             dec_bad, entry;

  assign entry = sleep_enter && !in_sr;

  psr_cfg_decode u_dec (
    .cfg_data (cfg_data),
    .half_mask(dec_mask),
    .bad      (dec_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      staged      <= '1;
      active      <= '1;
      retain_mask <= '1;
      in_sr       <= 1'b0;
      cfg_err     <= 1'b0;
    end else begin
      cfg_err <= cfg_we && dec_bad;
      if (cfg_we && !dec_bad) staged <= dec_mask;
      if (entry) begin
        active      <= staged;
        retain_mask <= whole_banks(staged);
        in_sr       <= 1'b1;
      end else if (sleep_exit && in_sr) begin
        in_sr <= 1'b0;
      end
    end
  end

  psr_refresh_seq #(.ROW_W(ROW_W), .REF_DIV(REF_DIV)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (entry),
    .in_sr   (in_sr),
    .act_half(active),
    .ref_stb (ref_stb),
    .ref_bank(ref_bank),
    .ref_row (ref_row)
  );

  psr_bank_track u_trk (
    .clk         (clk),
    .rst         (rst),
    .entry       (entry),
    .drop        (~whole_banks(staged)),
    .in_sr       (in_sr),
    .wr_stb      (wr_stb),
    .wr_bank     (wr_bank),
    .bank_invalid(bank_invalid)
  );

  // R8: a strobe only goes to a row whose half-bank is kept
  a_r8_stb_kept: assert property (@(posedge clk) disable iff (rst)
    ref_stb |-> active[{ref_bank, ref_row[ROW_W-1]}]);
  // R3: a rejected write leaves the staged setting alone
  a_r3_err_keeps: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> $stable(staged));
  // R9: after entry each bank is either kept whole or flagged
  a_r9_entry_cover: assert property (@(posedge clk) disable iff (rst)
    $rose(in_sr) |-> (&(bank_invalid | retain_mask)));
  // R10: a repeated entry request does not wake the device
  a_r10_stay_asleep: assert property (@(posedge clk) disable iff (rst)
    (in_sr && !sleep_exit) |=> in_sr);
endmodule

// File: tb/psr_ctrl_bench.sv
`timescale 1ns/1ps
module psr_ctrl_bench;
  localparam int ROW_W = 2;
  localparam int DIV   = 3;
  localparam int NPOS  = 8 * (1 << ROW_W);

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst = 1, cfg_we = 0, sleep_enter = 0, sleep_exit = 0, wr_stb = 0;
  logic [17:0] cfg_data = '0;
  logic [2:0]  wr_bank = '0;
  logic        in_sr, ref_stb, cfg_err;
  logic [2:0]  ref_bank;
  logic [ROW_W-1:0] ref_row;
  logic [7:0]  retain_mask, bank_invalid;

  psr_ctrl #(.ROW_W(ROW_W), .REF_DIV(DIV)) u_psr_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .sleep_enter(sleep_enter), .sleep_exit(sleep_exit),
    .wr_stb(wr_stb), .wr_bank(wr_bank), .in_sr(in_sr), .ref_stb(ref_stb),
    .ref_bank(ref_bank), .ref_row(ref_row), .retain_mask(retain_mask),
    .bank_invalid(bank_invalid), .cfg_err(cfg_err));

  int total = 0, bad = 0;
  // reference state
  bit [15:0] m_staged, m_active;
  bit [7:0]  m_ret, m_inv;
  bit        m_sr, m_stb, m_err;
  int        m_tmr, m_pos, m_bank, m_row;

  function automatic bit [16:0] ref_cfg(bit [17:0] d);
    bit [15:0] m = 0; int n = 16; bit bd = 0;
    case (d[17:16])
      2'd0: begin
        case (d[2:0])
          0: n = 16; 1: n = 8; 2: n = 4; 5: n = 2; 6: n = 1;
          default: bd = 1;
        endcase
        for (int i = 0; i < n; i++) m[i] = 1;
      end
      2'd1: begin
        n = 16 / (1 << d[1:0]);
        for (int i = 0; i < n; i++) m[d[2] ? 15 - i : i] = 1;
      end
      2'd2: for (int b = 0; b < 8; b++) begin m[2*b] = d[b]; m[2*b+1] = d[b]; end
      default: m = d[15:0];
    endcase
    return {bd, m};
  endfunction

  function automatic bit [7:0] full_of(bit [15:0] h);
    bit [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = h[2*b] && h[2*b+1];
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit [16:0] c;
    bit [15:0] old_staged = m_staged;
    if (rst) begin
      m_staged = '1; m_active = '1; m_ret = '1; m_inv = 0;
      m_sr = 0; m_stb = 0; m_err = 0; m_tmr = 0; m_pos = 0; m_bank = 0; m_row = 0;
      return;
    end
    m_err = 0;
    if (cfg_we) begin
      c = ref_cfg(cfg_data);
      m_err = c[16];
      if (!c[16]) m_staged = c[15:0];
    end
    m_stb = 0;
    if (!m_sr) begin
      if (sleep_enter) begin
        m_sr = 1; m_active = old_staged; m_ret = full_of(old_staged);
        m_inv |= ~full_of(old_staged); m_tmr = 0; m_pos = 0;
      end else if (wr_stb) m_inv[wr_bank] = 0;
    end else begin
      if (m_tmr == DIV - 1) begin
        m_bank = m_pos / (1 << ROW_W);
        m_row  = m_pos % (1 << ROW_W);
        m_stb  = m_active[2 * m_bank + (m_row >= (1 << (ROW_W - 1)))];
        m_pos  = (m_pos + 1) % NPOS;
        m_tmr  = 0;
      end else m_tmr++;
      if (sleep_exit) m_sr = 0;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(in_sr === m_sr, "R10", "in_sr", in_sr, m_sr);
    chk(ref_stb === m_stb, "R8", "ref_stb", ref_stb, m_stb);
    if (m_stb) begin
      chk(ref_bank === 3'(m_bank), "R8", "ref_bank", ref_bank, m_bank);
      chk(ref_row === ROW_W'(m_row), "R6", "ref_row", ref_row, m_row);
    end
    chk(retain_mask === m_ret, "R7", "retain_mask", retain_mask, m_ret);
    chk(bank_invalid === m_inv, "R9", "bank_invalid", bank_invalid, m_inv);
    chk(cfg_err === m_err, "R3", "cfg_err", cfg_err, m_err);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic put_cfg(bit [17:0] d);
    cfg_we = 1; cfg_data = d; tick(); cfg_we = 0;
  endtask

  task automatic enter(); sleep_enter = 1; tick(); sleep_enter = 0; endtask
  task automatic leave(); sleep_exit = 1;  tick(); sleep_exit = 0;  endtask
  task automatic wr(bit [2:0] b); wr_stb = 1; wr_bank = b; tick(); wr_stb = 0; endtask

  task automatic sleep_cycle(bit [17:0] d);
    put_cfg(d); run(2); enter(); run(NPOS * DIV + 5); leave(); run(3);
  endtask

  initial begin
    run(3);
    rst = 0;
    tick();
    // R1: reset values
    chk(in_sr === 0 && ref_stb === 0 && cfg_err === 0, "R1", "ctl", {in_sr, ref_stb, cfg_err}, 0);
    chk(retain_mask === 8'hFF && bank_invalid === 0, "R1", "masks", {retain_mask, bank_invalid}, 16'hFF00);
    // R1/R8: default keeps all, full sweep
    enter(); run(NPOS * DIV + 2); leave(); run(2);
    // R2: prefix codes
    sleep_cycle(18'h00001);
    sleep_cycle(18'h00002);
    sleep_cycle(18'h00005);
    sleep_cycle(18'h00006);
    // R3: reserved codes leave the 1/16 setting in place
    put_cfg(18'h00003); put_cfg(18'h00004); put_cfg(18'h00007);
    run(2); enter(); run(40); leave(); run(2);
    // R9: clear flags by writes while awake
    for (int b = 0; b < 8; b++) wr(3'(b));
    // R4: end-anchored
    sleep_cycle(18'h10006);
    sleep_cycle(18'h10003);
    sleep_cycle(18'h10001);
    // R5: bank mask
    sleep_cycle(18'h200A5);
    // R6: half-bank mask
    sleep_cycle(18'h3C396);
    // R7/R9/R10: write and bank writes during sleep, double entry
    put_cfg(18'h00000); run(1); enter(); run(7);
    put_cfg(18'h00002); wr(3'd5); enter(); run(NPOS * DIV);
    // R8: exit on a step edge
    while (!(m_tmr == DIV - 1)) tick();
    leave(); leave(); run(2);
    enter(); run(NPOS * DIV + 4); leave(); wr(3'd7); run(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule